// File: doc/BRIEF.md
# Two-Sided Command Mailbox with Buffer Semaphore

The block lets an internal bus master and an external host exchange short control messages. Each direction has its own 8-bit command register and a one-bit pending flag. A write to a command register raises its flag. A read of that command by the receiving side lowers the flag again. The flag that points toward the host also drives an active-low, open-drain style interrupt. The flag that points inward drives an active-high level interrupt for the internal side.

Larger payloads go through a shared byte buffer that both sides can address. Access to that buffer is coordinated by a two-bit hardware semaphore with acquire-on-read and release-on-write semantics.

Both sides see one 9-bit byte-address map through identical synchronous ports. Neither port has back-pressure: a request is accepted in every cycle that `*_req` is high. A read response appears with `*_rvalid` exactly one cycle later and cannot be stalled, so the consumer must take it in that cycle. A write produces no response.

Top module: `ctl_mailbox`

## Requirements
- R1: After reset, both command registers read 00h, both flags read 0, the semaphore reads 00b, `int_irq` is 0, `host_irq_n` is 1, and neither `*_rvalid` is high.
- R2: A read request (`req`=1, `we`=0) sampled at a clock edge gives `rvalid`=1 with its data after that edge, for exactly one cycle. A write request or an idle cycle gives `rvalid`=0.
- R3: A host write to address 000h stores the byte and sets the inbound flag at 002h. The internal side reads that byte at 000h. An internal write to 000h changes nothing. The same rules apply in mirror for the outbound command at 001h and its flag at 003h. A flag reads as 0000000 followed by the flag bit in bit 0.
- R4: An internal read of 000h clears the inbound flag. A host read of 000h returns the byte and leaves the flag unchanged.
- R5: A host read of 001h clears the outbound flag. An internal read of 001h leaves it unchanged.
- R6: Either side writing a byte with bit 0 equal to 0 to a flag address clears that flag. A write with bit 0 equal to 1 has no effect. If a command write and a clear of its flag happen in the same cycle, the flag ends up set.
- R7: The semaphore at 004h reads as 000000 followed by a 2-bit state: 00 free, 01 held by the internal side, 10 held by the host. A read while free grants the semaphore to the reader and returns the new state. A read while it is held returns the holder and changes nothing.
- R8: A write of 00h to 004h by the current owner frees the semaphore. Writes by the non-owner, and writes of any other value, are ignored.
- R9: If both sides read 004h in the same cycle while it is free, the internal side is granted, and both reads return 01.
- R10: `host_irq_n` is 0 exactly while the outbound flag is 1. `int_irq` is 1 exactly while the inbound flag is 1.
- R11: Addresses 005h to 1FFh are one shared byte buffer. A byte written there by either side can be read back by either side.
- R12: If both sides write the same buffer byte in the same cycle, the internal side's data is kept. A read of a byte in the same cycle as a write to it returns the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_req | input | 1 | Internal side access request |
| i_we | input | 1 | Internal side: 1 write, 0 read |
| i_addr | input | 9 | Internal side byte address |
| i_wdata | input | 8 | Internal side write data |
| i_rvalid | output | 1 | Internal side read data valid |
| i_rdata | output | 8 | Internal side read data |
| h_req | input | 1 | Host side access request |
| h_we | input | 1 | Host side: 1 write, 0 read |
| h_addr | input | 9 | Host side byte address |
| h_wdata | input | 8 | Host side write data |
| h_rvalid | output | 1 | Host side read data valid |
| h_rdata | output | 8 | Host side read data |
| int_irq | output | 1 | Level interrupt to the internal side, high while an inbound command is pending |
| host_irq_n | output | 1 | Active-low interrupt to the host, low while an outbound command is pending |

## Verification
The bench aims at same-cycle collisions, because those are where a wrong design silently diverges:
- A command write that coincides with a clear of its flag must leave the flag set. A design that lets the clear win loses a message.
- When both sides read the free semaphore in one cycle, both must be told the internal side owns it. A design that returns the pre-grant value lets both sides believe they own the buffer.
- When both sides write the same buffer byte, the internal side's data must survive. The wrong write order keeps the host's byte.
- A read that coincides with a write of the same byte must return the old data.

It also probes the ignored cases: a wrong-side command write, a non-owner release, a nonzero release value, and a host read of the inbound command. A design that acts on any of these shows a changed register or a moved interrupt on the next read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t A_CMD_BASE = addr_t'(0);  // 0: host->internal, 1: internal->host
  localparam addr_t A_AV_BASE  = addr_t'(2);  // 2: inbound flag, 3: outbound flag
  localparam addr_t A_SEM      = addr_t'(4);
  localparam addr_t A_BUF_LO   = addr_t'(5);

  typedef enum logic [1:0] {
    SEM_FREE = 2'b00,
    SEM_INT  = 2'b01,
    SEM_HOST = 2'b10
  } sem_t;

  function automatic data_t reg_view(addr_t a, data_t c_in, data_t c_out,
                                     logic av_in, logic av_out, sem_t s);
    data_t v;
    v = '0;
    if (a == A_CMD_BASE)              v = c_in;
    else if (a == A_CMD_BASE + 1'b1)  v = c_out;
    else if (a == A_AV_BASE)          v[0] = av_in;
    else if (a == A_AV_BASE + 1'b1)   v[0] = av_out;
    else if (a == A_SEM)              v[1:0] = s;
    return v;
  endfunction
endpackage

// File: rtl/mbx_cmd_chan.sv
module mbx_cmd_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take,
  input  logic         clr,
  output logic [W-1:0] cmd,
  output logic         avail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd   <= '0;
      avail <= 1'b0;
    end else begin
      if (load) cmd <= load_data;
      if (load)             avail <= 1'b1;
      else if (take || clr) avail <= 1'b0;
    end
  end

  assert_load_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (avail && cmd == $past(load_data)));
  assert_take_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !avail);
  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && clr) |=> avail);
  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !take && !clr) |=> ($stable(avail) && $stable(cmd)));
endmodule

// File: rtl/mbx_sem.sv
module mbx_sem
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic i_acq,
  input  logic h_acq,
  input  logic i_rel,
  input  logic h_rel,
  output sem_t state,
  output sem_t state_nx
);
  always_comb begin
    state_nx = state;
    unique case (state)
      SEM_FREE: begin
        if (i_acq)      state_nx = SEM_INT;   // internal side wins a tie
        else if (h_acq) state_nx = SEM_HOST;
      end
      SEM_INT:  if (i_rel) state_nx = SEM_FREE;
      SEM_HOST: if (h_rel) state_nx = SEM_FREE;
      default:  state_nx = SEM_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEM_FREE;
    else        state <= state_nx;
  end

  assert_tie_int_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEM_FREE && i_acq && h_acq) |=> state == SEM_INT);
  assert_host_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEM_FREE && h_acq && !i_acq) |=> state == SEM_HOST);
  assert_int_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEM_INT && !i_rel) |=> state == SEM_INT);
  assert_host_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEM_HOST && !h_rel) |=> state == SEM_HOST);
endmodule

// File: rtl/mbx_dpram.sv
module mbx_dpram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_q,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // Port a is written last, so it owns a same-address collision.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    if (a_we) mem[a_addr] <= a_wd;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/ctl_mailbox.sv
module ctl_mailbox
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_req,
  input  logic              i_we,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic [DATA_W-1:0] i_wdata,
  output logic              i_rvalid,
  output logic [DATA_W-1:0] i_rdata,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              h_rvalid,
  output logic [DATA_W-1:0] h_rdata,
  output logic              int_irq,
  output logic              host_irq_n
);
  localparam int SIDES = 2;   // 0: internal, 1: host
  localparam int CHANS = 2;   // 0: host->internal, 1: internal->host

  logic  rd [SIDES];
  logic  wr [SIDES];
  addr_t ad [SIDES];
  data_t wd [SIDES];

  assign rd[0] = i_req && !i_we;
  assign wr[0] = i_req && i_we;
  assign ad[0] = i_addr;
  assign wd[0] = i_wdata;
  assign rd[1] = h_req && !h_we;
  assign wr[1] = h_req && h_we;
  assign ad[1] = h_addr;
  assign wd[1] = h_wdata;

  logic  ld   [CHANS];
  data_t ld_d [CHANS];
  logic  tk   [CHANS];
  logic  cl   [CHANS];
  data_t cmd  [CHANS];
  logic  av   [CHANS];

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    localparam int    WS  = (c == 0) ? 1 : 0;   // writing side
    localparam int    RS  = 1 - WS;             // reading side
    localparam addr_t CA  = A_CMD_BASE + addr_t'(c);
    localparam addr_t AVA = A_AV_BASE + addr_t'(c);

    assign ld[c]   = wr[WS] && ad[WS] == CA;
    assign ld_d[c] = wd[WS];
    assign tk[c]   = rd[RS] && ad[RS] == CA;
    assign cl[c]   = (wr[0] && ad[0] == AVA && !wd[0][0]) ||
                     (wr[1] && ad[1] == AVA && !wd[1][0]);

    mbx_cmd_chan #(.W(DATA_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld[c]),
      .load_data (ld_d[c]),
      .take      (tk[c]),
      .clr       (cl[c]),
      .cmd       (cmd[c]),
      .avail     (av[c])
    );
  end

  sem_t sem_q, sem_nx;
  mbx_sem u_sem (
    .clk      (clk),
    .rst_n    (rst_n),
    .i_acq    (rd[0] && ad[0] == A_SEM),
    .h_acq    (rd[1] && ad[1] == A_SEM),
    .i_rel    (wr[0] && ad[0] == A_SEM && wd[0] == '0),
    .h_rel    (wr[1] && ad[1] == A_SEM && wd[1] == '0),
    .state    (sem_q),
    .state_nx (sem_nx)
  );

  data_t bq [SIDES];
  mbx_dpram #(.AW(ADDR_W), .DW(DATA_W)) u_buf (
    .clk    (clk),
    .a_we   (wr[0] && ad[0] >= A_BUF_LO),
    .a_addr (ad[0]),
    .a_wd   (wd[0]),
    .a_q    (bq[0]),
    .b_we   (wr[1] && ad[1] >= A_BUF_LO),
    .b_addr (ad[1]),
    .b_wd   (wd[1]),
    .b_q    (bq[1])
  );

  logic  rv   [SIDES];
  data_t rdat [SIDES];

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic  rv_q, bsel_q;
    data_t reg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rv_q   <= 1'b0;
        bsel_q <= 1'b0;
        reg_q  <= '0;
      end else begin
        rv_q <= rd[s];
        if (rd[s]) begin
          bsel_q <= ad[s] >= A_BUF_LO;
          // semaphore reads return the post-grant state
          reg_q  <= reg_view(ad[s], cmd[0], cmd[1], av[0], av[1], sem_nx);
        end
      end
    end
    assign rv[s]   = rv_q;
    assign rdat[s] = bsel_q ? bq[s] : reg_q;
  end

  assign i_rvalid   = rv[0];
  assign i_rdata    = rdat[0];
  assign h_rvalid   = rv[1];
  assign h_rdata    = rdat[1];
  assign int_irq    = av[0];
  assign host_irq_n = !av[1];

  assert_int_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && !i_we) |=> i_rvalid);
  assert_int_no_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(i_req && !i_we) |=> !i_rvalid);
  assert_host_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_we) |=> h_rvalid);
  assert_host_irq_on_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && i_we && i_addr == A_CMD_BASE + 1'b1) |=> !host_irq_n);
  assert_int_irq_on_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_we && h_addr == A_CMD_BASE) |=> int_irq);
endmodule

// File: tb/ctl_mailbox_test.sv
`timescale 1ns/1ps
module ctl_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       i_req = 0, i_we = 0, h_req = 0, h_we = 0;
  logic [8:0] i_addr = 0, h_addr = 0;
  logic [7:0] i_wdata = 0, h_wdata = 0;
  logic       i_rvalid, h_rvalid, int_irq, host_irq_n;
  logic [7:0] i_rdata, h_rdata;

  always #2 clk = ~clk;

  ctl_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .i_req(i_req), .i_we(i_we), .i_addr(i_addr), .i_wdata(i_wdata),
    .i_rvalid(i_rvalid), .i_rdata(i_rdata),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .int_irq(int_irq), .host_irq_n(host_irq_n)
  );

  int checks = 0;
  int errors = 0;

  // reference state built from the requirements
  logic [7:0] m_cmd [2];   // 0 inbound (000h), 1 outbound (001h)
  logic       m_av  [2];   // 0 at 002h, 1 at 003h
  logic [1:0] m_sem;
  logic [7:0] m_mem [512];

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [8:0] a);
    if (a <= 9'd1) return "R3";
    if (a <= 9'd3) return "R6";
    if (a == 9'd4) return "R7";
    return "R11";
  endfunction

  function automatic logic [1:0] sem_next(input bit ir, iw, input logic [8:0] ia, input logic [7:0] id,
                                          input bit hr, hw, input logic [8:0] ha, input logic [7:0] hd);
    bit ia4 = ir && !iw && ia == 9'd4;
    bit ha4 = hr && !hw && ha == 9'd4;
    if (m_sem == 2'b00) return ia4 ? 2'b01 : (ha4 ? 2'b10 : 2'b00);
    if (m_sem == 2'b01) return (ir && iw && ia == 9'd4 && id == 8'h00) ? 2'b00 : 2'b01;
    return (hr && hw && ha == 9'd4 && hd == 8'h00) ? 2'b00 : 2'b10;
  endfunction

  function automatic logic [7:0] view(input logic [8:0] a, input logic [1:0] s_new);
    if (a == 9'd0) return m_cmd[0];
    if (a == 9'd1) return m_cmd[1];
    if (a == 9'd2) return {7'd0, m_av[0]};
    if (a == 9'd3) return {7'd0, m_av[1]};
    if (a == 9'd4) return {6'd0, s_new};
    return m_mem[a];
  endfunction

  // one cycle: drive at a falling edge, check after the next falling edge
  task automatic step(input string tag, input bit ir, iw, input logic [8:0] ia, input logic [7:0] id,
                      input bit hr, hw, input logic [8:0] ha, input logic [7:0] hd);
    logic [1:0] s_new;
    logic [7:0] ei, eh;
    bit ev_i, ev_h, set0, set1, clr0, clr1;
    s_new = sem_next(ir, iw, ia, id, hr, hw, ha, hd);
    ev_i = ir && !iw;
    ev_h = hr && !hw;
    ei = view(ia, s_new);
    eh = view(ha, s_new);
    set0 = hr && hw && ha == 9'd0;
    set1 = ir && iw && ia == 9'd1;
    clr0 = (ir && !iw && ia == 9'd0) || (ir && iw && ia == 9'd2 && !id[0]) || (hr && hw && ha == 9'd2 && !hd[0]);
    clr1 = (hr && !hw && ha == 9'd1) || (ir && iw && ia == 9'd3 && !id[0]) || (hr && hw && ha == 9'd3 && !hd[0]);
    if (set0) m_cmd[0] = hd;
    if (set1) m_cmd[1] = id;
    m_av[0] = set0 ? 1'b1 : (clr0 ? 1'b0 : m_av[0]);
    m_av[1] = set1 ? 1'b1 : (clr1 ? 1'b0 : m_av[1]);
    m_sem = s_new;
    if (hr && hw && ha >= 9'd5) m_mem[ha] = hd;
    if (ir && iw && ia >= 9'd5) m_mem[ia] = id;   // internal side kept on a collision
    i_req = ir; i_we = iw; i_addr = ia; i_wdata = id;
    h_req = hr; h_we = hw; h_addr = ha; h_wdata = hd;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "i_rvalid", {7'd0, i_rvalid}, {7'd0, ev_i});
    chk("R2", "h_rvalid", {7'd0, h_rvalid}, {7'd0, ev_h});
    if (ev_i) chk(tag, "i_rdata", i_rdata, ei);
    if (ev_h) chk(tag, "h_rdata", h_rdata, eh);
    chk("R10", "int_irq", {7'd0, int_irq}, {7'd0, m_av[0]});
    chk("R10", "host_irq_n", {7'd0, host_irq_n}, {7'd0, !m_av[1]});
  endtask

  task automatic idle();
    step("R2", 0, 0, 9'd0, 8'd0, 0, 0, 9'd0, 8'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    m_cmd[0] = 0; m_cmd[1] = 0; m_av[0] = 0; m_av[1] = 0; m_sem = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports, then every register reads zero
    chk("R1", "i_rvalid", {7'd0, i_rvalid}, 8'd0);
    chk("R1", "h_rvalid", {7'd0, h_rvalid}, 8'd0);
    chk("R1", "int_irq", {7'd0, int_irq}, 8'd0);
    chk("R1", "host_irq_n", {7'd0, host_irq_n}, 8'd1);
    for (int a = 0; a < 4; a++) step("R1", 1, 0, 9'(a), 8'd0, 1, 0, 9'(a), 8'd0);
    chk("R1", "semaphore free", {6'd0, m_sem}, 8'd0);

    // R11: fill the buffer from alternating sides, read back across sides
    for (int a = 5; a < 512; a++) begin
      if (a[0]) step("R11", 1, 1, 9'(a), 8'(a * 7 + 3), 0, 0, 9'd0, 8'd0);
      else      step("R11", 0, 0, 9'd0, 8'd0, 1, 1, 9'(a), 8'(a * 7 + 3));
    end
    step("R11", 1, 0, 9'd6, 8'd0, 1, 0, 9'd7, 8'd0);
    chk("R11", "cross read 006h", i_rdata, 8'(6 * 7 + 3));

    // R3/R4: inbound command
    step("R3", 0, 0, 9'd0, 8'd0, 1, 1, 9'd0, 8'hA5);
    step("R3", 1, 1, 9'd0, 8'h3C, 0, 0, 9'd0, 8'd0);          // wrong-side write ignored
    step("R4", 0, 0, 9'd0, 8'd0, 1, 0, 9'd0, 8'd0);           // host read keeps flag
    step("R4", 1, 0, 9'd2, 8'd0, 0, 0, 9'd0, 8'd0);
    chk("R4", "flag kept after host read", i_rdata, 8'h01);
    step("R4", 1, 0, 9'd0, 8'd0, 0, 0, 9'd0, 8'd0);
    chk("R3", "inbound command", i_rdata, 8'hA5);
    step("R4", 0, 0, 9'd0, 8'd0, 1, 0, 9'd2, 8'd0);
    chk("R4", "flag cleared", h_rdata, 8'h00);

    // R5/R10: outbound command
    step("R10", 1, 1, 9'd1, 8'h77, 0, 0, 9'd0, 8'd0);
    chk("R10", "host_irq_n asserted", {7'd0, host_irq_n}, 8'd0);
    step("R5", 1, 0, 9'd1, 8'd0, 0, 0, 9'd0, 8'd0);           // internal read keeps flag
    step("R5", 0, 0, 9'd0, 8'd0, 1, 0, 9'd1, 8'd0);
    chk("R5", "outbound command", h_rdata, 8'h77);
    chk("R5", "host_irq_n released", {7'd0, host_irq_n}, 8'd1);

    // R6: write-1 no effect, write-0 clears, set beats clear
    step("R6", 0, 0, 9'd0, 8'd0, 1, 1, 9'd2, 8'hFF);
    chk("R6", "write one ignored", {7'd0, int_irq}, 8'd0);
    step("R6", 0, 0, 9'd0, 8'd0, 1, 1, 9'd0, 8'h11);
    step("R6", 1, 1, 9'd2, 8'hFE, 0, 0, 9'd0, 8'd0);
    chk("R6", "write zero clears", {7'd0, int_irq}, 8'd0);
    step("R6", 1, 1, 9'd2, 8'h00, 1, 1, 9'd0, 8'h22);
    chk("R6", "set beats clear", {7'd0, int_irq}, 8'd1);
    step("R6", 0, 0, 9'd0, 8'd0, 1, 1, 9'd2, 8'h00);

    // R7/R8: semaphore
    step("R7", 1, 0, 9'd4, 8'd0, 0, 0, 9'd0, 8'd0);
    chk("R7", "internal grant", i_rdata, 8'h01);
    step("R7", 0, 0, 9'd0, 8'd0, 1, 0, 9'd4, 8'd0);
    chk("R7", "held read", h_rdata, 8'h01);
    step("R8", 0, 0, 9'd0, 8'd0, 1, 1, 9'd4, 8'h00);          // non-owner release
    step("R8", 1, 1, 9'd4, 8'h02, 0, 0, 9'd0, 8'd0);          // nonzero value
    step("R8", 1, 0, 9'd4, 8'd0, 0, 0, 9'd0, 8'd0);
    chk("R8", "still internal", i_rdata, 8'h01);
    step("R8", 1, 1, 9'd4, 8'h00, 0, 0, 9'd0, 8'd0);
    step("R7", 0, 0, 9'd0, 8'd0, 1, 0, 9'd4, 8'd0);
    chk("R7", "host grant", h_rdata, 8'h02);
    step("R8", 1, 1, 9'd4, 8'h00, 0, 0, 9'd0, 8'd0);
    step("R8", 0, 0, 9'd0, 8'd0, 1, 1, 9'd4, 8'h00);

    // R9: simultaneous acquire
    step("R9", 1, 0, 9'd4, 8'd0, 1, 0, 9'd4, 8'd0);
    chk("R9", "tie internal view", i_rdata, 8'h01);
    chk("R9", "tie host view", h_rdata, 8'h01);
    step("R9", 1, 1, 9'd4, 8'h00, 0, 0, 9'd0, 8'd0);

    // R12: buffer collisions
    step("R12", 1, 1, 9'd9, 8'hC1, 1, 1, 9'd9, 8'hD2);
    step("R12", 0, 0, 9'd0, 8'd0, 1, 0, 9'd9, 8'd0);
    chk("R12", "internal wins", h_rdata, 8'hC1);
    step("R12", 1, 1, 9'd9, 8'h5E, 1, 0, 9'd9, 8'd0);
    chk("R12", "read old on write", h_rdata, 8'hC1);
    idle();

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit ir, iw, hr, hw;
      logic [8:0] ia, ha;
      logic [7:0] id, hd;
      ir = $urandom_range(0, 3) != 0;
      hr = $urandom_range(0, 3) != 0;
      iw = $urandom_range(0, 1) == 1;
      hw = $urandom_range(0, 1) == 1;
      ia = ($urandom_range(0, 1) == 1) ? 9'($urandom_range(0, 4)) : 9'($urandom_range(5, 12));
      ha = ($urandom_range(0, 1) == 1) ? 9'($urandom_range(0, 4)) : 9'($urandom_range(5, 12));
      id = ($urandom_range(0, 1) == 1) ? 8'h00 : 8'($urandom);
      hd = ($urandom_range(0, 1) == 1) ? 8'h00 : 8'($urandom);
      step(tag_of(ir ? ia : ha), ir, iw, ia, id, hr, hw, ha, hd);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule